// File: doc/BRIEF.md
# Addressed Serial Configuration Register Bank

This block receives configuration words over a three-line serial port made of a serial clock, a data line and a load/enable line. Each rising serial clock moves one data bit into a 24-bit shift register, most significant bit first. A rising edge on the enable line commits the word. The two top bits of the word choose one of four 22-bit holding registers, and the 22 lower bits are written into that register. The four registers drive the rest of the chip as parallel configuration words. A write touches only the register it addresses, so one field group can be changed without resending the others.

The enable line also selects the operating mode. After reset the block is in pin-controlled mode and ignores loads. The first level change seen on the enable line after reset moves the block into programmable mode for good, and that change does not load a register. All three serial inputs pass through synchronisers, so the block runs entirely on the system clock. The serial clock must therefore be slow compared with the system clock.

Each completed update raises a one-cycle strobe together with the address that was written. This is a plain indication with no ready signal: the update cannot be stalled, and downstream logic that needs it must capture it in that cycle.

Top module: `sercfg_bank`

## Requirements
- R1: On each rising edge of the synchronised serial clock, the synchronised data level is shifted into the least significant end of a 24-bit shift register. The first bit received ends up as bit 23.
- R2: If more than 24 bits arrive before a load, only the 24 most recently received bits are used.
- R3: A load writes bits 21:0 of the word into the register selected by bits 23:22: 0 selects cfg_a_o, 1 selects cfg_b_o, 2 selects cfg_c_o and 3 selects cfg_d_o.
- R4: A load changes only the addressed register. The other three keep their values.
- R5: A load happens only on a rising edge of the enable line. Serial clocking alone and a falling enable edge leave all registers unchanged.
- R6: After reset prog_mode_o is 0. The first level change on the enable line after reset sets it to 1, and it stays 1 until the next reset. Loads are ignored while it is 0, and the change that sets it writes no register.
- R7: A synchronous reset (rst high) clears all four registers and the shift register, and returns the block to pin-controlled mode.
- R8: Every register write raises upd_stb_o for exactly one cycle, with upd_addr_o equal to the written address, in the same cycle that the new value appears on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ser_clk_i | input | 1 | Serial clock, asynchronous to clk |
| ser_dat_i | input | 1 | Serial data, MSB first |
| ser_en_i | input | 1 | Load/enable line; also the mode pin |
| prog_mode_o | output | 1 | 1 once programmable mode is entered |
| upd_stb_o | output | 1 | One-cycle strobe for each register write |
| upd_addr_o | output | 2 | Address of the register just written |
| cfg_a_o | output | 22 | Holding register, address 0 |
| cfg_b_o | output | 22 | Holding register, address 1 |
| cfg_c_o | output | 22 | Holding register, address 2 |
| cfg_d_o | output | 22 | Holding register, address 3 |

## Verification
The hardest case to reach is a reset that releases while the enable pin is already high. The synchronisers refill from zero after reset, so a careless design sees a false first transition and leaves pin-controlled mode too early. The bench drives this case on purpose: it holds enable high through reset, waits, confirms the mode bit is still clear, and then lowers the pin. It also keeps enable high while a word is shifted, so that the falling edge must load nothing and only the next rising edge may commit the word.

// File: rtl/sercfg_pkg.sv
package sercfg_pkg;
  localparam int ADDR_W   = 2;
  localparam int NUM_REGS = 1 << ADDR_W;
  localparam int SYNC_STAGES = 2;

  typedef enum logic [ADDR_W-1:0] {
    CFG_SEL_A = 2'd0,
    CFG_SEL_B = 2'd1,
    CFG_SEL_C = 2'd2,
    CFG_SEL_D = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/sercfg_sync.sv
module sercfg_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg_q[0] <= '0;
    else     stg_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg_q[s] <= '0;
      else     stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/sercfg_mode.sv
module sercfg_mode #(
  parameter int SETTLE = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic en_s_i,
  output logic settled_o,
  output logic prog_o,
  output logic load_o
);
  localparam int CNT_W = $clog2(SETTLE + 1);

  logic [CNT_W-1:0] settle_cnt_q;
  logic             en_prev_q;
  logic             prog_q;
  logic             settled;

  assign settled = (settle_cnt_q == CNT_W'(SETTLE));

  always_ff @(posedge clk) begin
    if (rst) begin
      settle_cnt_q <= '0;
      en_prev_q    <= 1'b0;
      prog_q       <= 1'b0;
    end else begin
      en_prev_q <= en_s_i;
      if (!settled) settle_cnt_q <= settle_cnt_q + 1'b1;
      if (settled && (en_s_i != en_prev_q)) prog_q <= 1'b1;
    end
  end

  // the registered mode bit gates loads, so the mode-changing edge loads nothing
  assign load_o    = settled && prog_q && en_s_i && !en_prev_q;
  assign prog_o    = prog_q;
  assign settled_o = settled;
endmodule

// File: rtl/sercfg_shifter.sv
module sercfg_shifter #(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_i,
  input  logic              sclk_s_i,
  input  logic              dat_s_i,
  output logic [WORD_W-1:0] word_o
);
  logic              sclk_prev_q;
  logic [WORD_W-1:0] shreg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_prev_q <= 1'b0;
      shreg_q     <= '0;
    end else begin
      sclk_prev_q <= sclk_s_i;
      if (run_i && sclk_s_i && !sclk_prev_q)
        shreg_q <= {shreg_q[WORD_W-2:0], dat_s_i};
    end
  end

  assign word_o = shreg_q;
endmodule

// File: rtl/sercfg_regfile.sv
module sercfg_regfile
  import sercfg_pkg::*;
#(
  parameter int DATA_W = 22
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     load_i,
  input  logic [ADDR_W+DATA_W-1:0] word_i,
  output logic [DATA_W-1:0]        regs_o [NUM_REGS],
  output logic                     stb_o,
  output logic [ADDR_W-1:0]        addr_o
);
  localparam int WORD_W = ADDR_W + DATA_W;

  logic [ADDR_W-1:0] sel;
  logic [DATA_W-1:0] regs_q [NUM_REGS];

  assign sel = word_i[WORD_W-1 -: ADDR_W];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        regs_q[g] <= '0;
      else if (load_i && (sel == ADDR_W'(g)))
        regs_q[g] <= word_i[DATA_W-1:0];
    end
    assign regs_o[g] = regs_q[g];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stb_o  <= 1'b0;
      addr_o <= '0;
    end else begin
      stb_o <= load_i;
      if (load_i) addr_o <= sel;
    end
  end
endmodule

// File: rtl/sercfg_bank.sv
module sercfg_bank
  import sercfg_pkg::*;
#(
  parameter int DATA_W = 22
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_clk_i,
  input  logic              ser_dat_i,
  input  logic              ser_en_i,
  output logic              prog_mode_o,
  output logic              upd_stb_o,
  output logic [ADDR_W-1:0] upd_addr_o,
  output logic [DATA_W-1:0] cfg_a_o,
  output logic [DATA_W-1:0] cfg_b_o,
  output logic [DATA_W-1:0] cfg_c_o,
  output logic [DATA_W-1:0] cfg_d_o
);
  localparam int WORD_W = ADDR_W + DATA_W;
  localparam int SETTLE = SYNC_STAGES + 1;

  logic [2:0]        sync_q;
  logic              settled;
  logic              load;
  logic [WORD_W-1:0] word;
  logic [DATA_W-1:0] regs [NUM_REGS];

  sercfg_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({ser_en_i, ser_dat_i, ser_clk_i}),
    .q_o (sync_q)
  );

  sercfg_mode #(.SETTLE(SETTLE)) u_mode (
    .clk       (clk),
    .rst       (rst),
    .en_s_i    (sync_q[2]),
    .settled_o (settled),
    .prog_o    (prog_mode_o),
    .load_o    (load)
  );

  sercfg_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .run_i    (settled),
    .sclk_s_i (sync_q[0]),
    .dat_s_i  (sync_q[1]),
    .word_o   (word)
  );

  sercfg_regfile #(.DATA_W(DATA_W)) u_regs (
    .clk    (clk),
    .rst    (rst),
    .load_i (load),
    .word_i (word),
    .regs_o (regs),
    .stb_o  (upd_stb_o),
    .addr_o (upd_addr_o)
  );

  assign cfg_a_o = regs[CFG_SEL_A];
  assign cfg_b_o = regs[CFG_SEL_B];
  assign cfg_c_o = regs[CFG_SEL_C];
  assign cfg_d_o = regs[CFG_SEL_D];
endmodule

// File: rtl/sercfg_bank_chk.sv
module sercfg_bank_chk #(
  parameter int DATA_W = 22
) (
  input logic              clk,
  input logic              rst,
  input logic              prog_mode_o,
  input logic              upd_stb_o,
  input logic [1:0]        upd_addr_o,
  input logic [DATA_W-1:0] cfg_a_o,
  input logic [DATA_W-1:0] cfg_b_o,
  input logic [DATA_W-1:0] cfg_c_o,
  input logic [DATA_W-1:0] cfg_d_o
);
  // R6
  mode_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    prog_mode_o |=> prog_mode_o);

  // R6
  no_pin_mode_load_chk: assert property (@(posedge clk) disable iff (rst)
    upd_stb_o |-> $past(prog_mode_o));

  // R8
  stb_single_chk: assert property (@(posedge clk) disable iff (rst)
    upd_stb_o |=> !upd_stb_o);

  // R4
  a_only_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(cfg_a_o) |-> (upd_stb_o && upd_addr_o == 2'd0));

  // R4
  b_only_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(cfg_b_o) |-> (upd_stb_o && upd_addr_o == 2'd1));

  // R4
  c_only_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(cfg_c_o) |-> (upd_stb_o && upd_addr_o == 2'd2));

  // R4
  d_only_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(cfg_d_o) |-> (upd_stb_o && upd_addr_o == 2'd3));
endmodule

bind sercfg_bank sercfg_bank_chk #(.DATA_W(DATA_W)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .prog_mode_o (prog_mode_o),
  .upd_stb_o   (upd_stb_o),
  .upd_addr_o  (upd_addr_o),
  .cfg_a_o     (cfg_a_o),
  .cfg_b_o     (cfg_b_o),
  .cfg_c_o     (cfg_c_o),
  .cfg_d_o     (cfg_d_o)
);

// File: tb/sercfg_bank_tb.sv
module sercfg_bank_tb_top;
  localparam int DW = 22;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ser_clk = 1'b0, ser_dat = 1'b0, ser_en = 1'b0;
  logic          prog_mode_o, upd_stb_o;
  logic [1:0]    upd_addr_o;
  logic [DW-1:0] cfg_a_o, cfg_b_o, cfg_c_o, cfg_d_o;

  int n_tests = 0;
  int n_fail  = 0;
  int stb_cnt = 0;
  logic [1:0]    stb_addr = '0;
  logic [DW-1:0] exp_q [4];

  always #2 clk = ~clk;

  sercfg_bank #(.DATA_W(DW)) dut_i (
    .clk(clk), .rst(rst), .ser_clk_i(ser_clk), .ser_dat_i(ser_dat),
    .ser_en_i(ser_en), .prog_mode_o(prog_mode_o), .upd_stb_o(upd_stb_o),
    .upd_addr_o(upd_addr_o), .cfg_a_o(cfg_a_o), .cfg_b_o(cfg_b_o),
    .cfg_c_o(cfg_c_o), .cfg_d_o(cfg_d_o)
  );

  always @(negedge clk) begin
    if (upd_stb_o) begin
      stb_cnt  = stb_cnt + 1;
      stb_addr = upd_addr_o;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [DW-1:0] get_reg(input int i);
    case (i)
      0: return cfg_a_o;
      1: return cfg_b_o;
      2: return cfg_c_o;
      default: return cfg_d_o;
    endcase
  endfunction

  function automatic logic [23:0] mk_word(input logic [1:0] a, input logic [DW-1:0] d);
    return {a, d};
  endfunction

  task automatic check_regs(input string req);
    for (int i = 0; i < 4; i++) chk(req, 32'(get_reg(i)), 32'(exp_q[i]));
  endtask

  task automatic send_bit(input logic b);
    ser_dat = b;
    wait_clk(4);
    ser_clk = 1'b1;
    wait_clk(4);
    ser_clk = 1'b0;
  endtask

  task automatic send_word(input logic [23:0] w, input int extra);
    for (int i = 0; i < extra; i++) send_bit(1'($urandom));
    for (int i = 23; i >= 0; i--) send_bit(w[i]);
  endtask

  task automatic pulse_en;
    wait_clk(4);
    ser_en = 1'b1;
    wait_clk(8);
    ser_en = 1'b0;
    wait_clk(8);
  endtask

  task automatic do_reset;
    rst = 1'b1;
    wait_clk(4);
    rst = 1'b0;
    wait_clk(6);
    for (int i = 0; i < 4; i++) exp_q[i] = '0;
  endtask

  // full write: R1 bit order, R3 decode, R4 isolation, R8 strobe
  task automatic write_reg(input logic [1:0] a, input logic [DW-1:0] d, input int extra,
                           input string req);
    send_word(mk_word(a, d), extra);
    stb_cnt = 0;
    pulse_en();
    exp_q[a] = d;
    chk({req, "/R8 strobe count"}, 32'(stb_cnt), 32'd1);
    chk({req, "/R8 strobe addr"}, 32'(stb_addr), 32'(a));
    check_regs({req, "/R3/R4 regs"});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1234));
    do_reset();
    // R7 reset state, R6 starts in pin mode
    chk("R6 mode after reset", 32'(prog_mode_o), 32'd0);
    check_regs("R7 regs after reset");

    // R5: serial clocking with no enable edge loads nothing
    send_word(mk_word(2'd1, 22'h155555), 0);
    wait_clk(10);
    check_regs("R5 no load without enable edge");
    chk("R6 still pin mode", 32'(prog_mode_o), 32'd0);

    // R6: first transition enters programmable mode, loads nothing
    stb_cnt = 0;
    pulse_en();
    chk("R6 mode entered", 32'(prog_mode_o), 32'd1);
    chk("R6 transition strobe", 32'(stb_cnt), 32'd0);
    check_regs("R6 transition no load");

    // R3 directed: every address, distinctive payloads (R1 bit order)
    write_reg(2'd0, 22'h2aaaaa, 0, "R1/R3 A");
    write_reg(2'd1, 22'h155555, 0, "R1/R3 B");
    write_reg(2'd2, 22'h3c0f0f, 0, "R1/R3 C");
    write_reg(2'd3, 22'h000001, 0, "R1/R3 D");

    // R2: extra leading bits dropped
    write_reg(2'd2, 22'h12345a, 7, "R2 extra bits");
    write_reg(2'd0, 22'h3fffff, 1, "R2 one extra bit");

    // R5: enable already high during shifting; the falling edge must not load
    ser_en = 1'b1;
    wait_clk(10);
    send_word(mk_word(2'd3, 22'h0abcde), 0);
    stb_cnt = 0;
    wait_clk(4);
    ser_en = 1'b0;
    wait_clk(10);
    chk("R5 falling edge strobe", 32'(stb_cnt), 32'd0);
    check_regs("R5 falling edge no load");
    ser_en = 1'b1;
    wait_clk(10);
    exp_q[3] = 22'h0abcde;
    chk("R5 rising edge strobe", 32'(stb_cnt), 32'd1);
    check_regs("R5 rising edge loads");
    ser_en = 1'b0;
    wait_clk(8);

    // random writes
    for (int k = 0; k < 40; k++) begin
      logic [1:0]    a;
      logic [DW-1:0] d;
      a = 2'($urandom);
      d = DW'($urandom);
      write_reg(a, d, int'($urandom_range(0, 7)), "R1/R2/R3/R4 random");
    end

    // R7: reset mid-run
    do_reset();
    chk("R7 mode cleared", 32'(prog_mode_o), 32'd0);
    check_regs("R7 regs cleared");

    // R6: reset released with enable high, no false mode entry
    ser_en = 1'b1;
    do_reset();
    wait_clk(20);
    chk("R6 high pin no false entry", 32'(prog_mode_o), 32'd0);
    stb_cnt = 0;
    ser_en = 1'b0;
    wait_clk(8);
    chk("R6 falling entry", 32'(prog_mode_o), 32'd1);
    chk("R6 falling entry no strobe", 32'(stb_cnt), 32'd0);
    check_regs("R6 falling entry no load");
    write_reg(2'd1, 22'h2468ac, 3, "R7 write after reset");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule